// File: doc/BRIEF.md
# Bidirectional Shift Register with Mode Select

This block is a parallel register of configurable width. On every rising clock edge it does one of four things, picked by a two-bit mode input: it keeps its contents, moves every bit one place toward bit 0, moves every bit one place toward the most significant bit, or takes a whole new word from the parallel data input. All bits are clocked from one common clock.

Each shift direction has its own serial input. A downward shift fills the vacated top bit from the downward serial input. An upward shift fills bit 0 from the upward serial input. The two end bits of the register also appear on separate serial outputs. A wider chain can therefore be built by wiring one register's end bit to its neighbour's serial input. A synchronous, active-high reset clears the register and overrides the mode.

Top module: `bidir_shift_reg`

## Requirements
- R1: With mode 2'b00 (keep) and reset low, `q` after a rising edge equals `q` before it.
- R2: With mode 2'b01 (toward bit 0), each rising edge sets `q[i]` to the old `q[i+1]` for i below WIDTH-1, and sets `q[WIDTH-1]` to `ser_in_down`.
- R3: With mode 2'b10 (toward the top bit), each rising edge sets `q[i]` to the old `q[i-1]` for i above 0, and sets `q[0]` to `ser_in_up`.
- R4: With mode 2'b11 (load), one rising edge copies `par_in` into `q`.
- R5: When `rst` is high at a rising edge, `q` becomes all zeros whatever the mode, load included.
- R6: `ser_out_up` always equals `q[WIDTH-1]`, and `ser_out_down` always equals `q[0]`.
- R7: Starting from any value, WIDTH consecutive shifts in one direction with that direction's serial input held at 0 leave `q` all zeros.
- R8: WIDTH is a parameter with a default of 4 and a minimum of 2. The register changes only at rising edges of `clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock; all updates on the rising edge |
| rst | input | 1 | Synchronous active-high clear |
| mode | input | 2 | 00 keep, 01 shift toward bit 0, 10 shift toward top bit, 11 parallel load |
| ser_in_up | input | 1 | Bit entering position 0 on an upward shift |
| ser_in_down | input | 1 | Bit entering the top position on a downward shift |
| par_in | input | WIDTH | Word copied in by the load mode |
| q | output | WIDTH | Stored word |
| ser_out_up | output | 1 | Top bit, the serial output for upward cascading |
| ser_out_down | output | 1 | Bit 0, the serial output for downward cascading |

## Verification
The cases hardest to reach from the ports are those where two rules compete. One is a reset arriving while load or shift is requested: the stimulus asserts reset with mode 11 and an all-ones word, and later in the middle of an upward run. The other is a bit travelling the whole length of the register: the stimulus loads a pattern and then shifts it out completely in each direction with zero fill, so every cell's neighbour path and both end paths are used. Long random mode and data sequences then run against a cycle-level model in the bench, with occasional resets mixed in.

// File: rtl/bdsr_pkg.sv
package bdsr_pkg;

    typedef enum logic [1:0] {
        MODE_KEEP = 2'b00,
        MODE_DOWN = 2'b01,
        MODE_UP   = 2'b10,
        MODE_LOAD = 2'b11
    } shift_mode_e;

    typedef struct packed {
        logic keep;
        logic down;
        logic up;
        logic load;
    } cell_sel_t;

    function automatic cell_sel_t decode_mode(input shift_mode_e m);
        cell_sel_t s;
        s = '0;
        unique case (m)
            MODE_KEEP: s.keep = 1'b1;
            MODE_DOWN: s.down = 1'b1;
            MODE_UP:   s.up   = 1'b1;
            MODE_LOAD: s.load = 1'b1;
            default:   s.keep = 1'b1;
        endcase
        return s;
    endfunction

    function automatic logic cell_next(input cell_sel_t s,
                                       input logic cur,
                                       input logic from_lo,
                                       input logic from_hi,
                                       input logic ld);
        logic n;
        n = cur;
        if (s.down)      n = from_hi;
        else if (s.up)   n = from_lo;
        else if (s.load) n = ld;
        return n;
    endfunction

endpackage

// File: rtl/bdsr_mode_dec.sv
module bdsr_mode_dec
    import bdsr_pkg::*;
(
    input  logic [1:0] mode,
    output cell_sel_t  sel
);
    always_comb begin
        sel = decode_mode(shift_mode_e'(mode));
    end
endmodule

// File: rtl/bdsr_bit_cell.sv
module bdsr_bit_cell
    import bdsr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cell_sel_t sel,
    input  logic      from_lo,
    input  logic      from_hi,
    input  logic      ld_bit,
    output logic      q
);
    logic q_nxt;

    always_comb begin
        q_nxt = cell_next(sel, q, from_lo, from_hi, ld_bit);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= q_nxt;
    end
endmodule

// File: rtl/bidir_shift_reg.sv
module bidir_shift_reg
    import bdsr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    input  logic             ser_in_up,
    input  logic             ser_in_down,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] q,
    output logic             ser_out_up,
    output logic             ser_out_down
);
    localparam int TOP = WIDTH - 1;

    cell_sel_t        sel;
    logic [WIDTH-1:0] lo_src;
    logic [WIDTH-1:0] hi_src;

    generate
        if (WIDTH < 2) begin : g_bad_width
            $error("bidir_shift_reg: WIDTH must be at least 2");
        end
    endgenerate

    bdsr_mode_dec u_dec (
        .mode (mode),
        .sel  (sel)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        if (i == 0) begin : g_lo_end
            assign lo_src[i] = ser_in_up;
        end else begin : g_lo_mid
            assign lo_src[i] = q[i-1];
        end
        if (i == TOP) begin : g_hi_end
            assign hi_src[i] = ser_in_down;
        end else begin : g_hi_mid
            assign hi_src[i] = q[i+1];
        end

        bdsr_bit_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .sel     (sel),
            .from_lo (lo_src[i]),
            .from_hi (hi_src[i]),
            .ld_bit  (par_in[i]),
            .q       (q[i])
        );
    end

    assign ser_out_up   = q[TOP];
    assign ser_out_down = q[0];

    // Mode behaviour checks
    p_keep_r1: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00) |=> (q == $past(q)));

    p_down_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01) |=> (q == {$past(ser_in_down), $past(q[TOP:1])}));

    p_up_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10) |=> (q == {$past(q[TOP-1:0]), $past(ser_in_up)}));

    p_load_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b11) |=> (q == $past(par_in)));

    p_clear_r5: assert property (@(posedge clk)
        rst |=> (q == '0));

    p_single_sel_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot({sel.keep, sel.down, sel.up, sel.load}));

endmodule

// File: tb/bidir_shift_reg_tb.sv
module bidir_shift_reg_tb;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic [1:0]   mode;
    logic         ser_in_up;
    logic         ser_in_down;
    logic [W-1:0] par_in;
    logic [W-1:0] q;
    logic         ser_out_up;
    logic         ser_out_down;

    typedef struct {
        logic [W-1:0] exp;
        string        tag;
    } item_t;

    item_t        sb[$];
    logic [W-1:0] model;
    int           n_checks = 0;
    int           n_fail   = 0;
    bit           done     = 1'b0;

    always #4 clk = ~clk;

    bidir_shift_reg #(.WIDTH(W)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .mode         (mode),
        .ser_in_up    (ser_in_up),
        .ser_in_down  (ser_in_down),
        .par_in       (par_in),
        .q            (q),
        .ser_out_up   (ser_out_up),
        .ser_out_down (ser_out_down)
    );

    // Driver: sets inputs at a falling edge, updates the model, pushes the expectation
    task automatic drive(input logic r, input logic [1:0] m, input logic su,
                         input logic sd, input logic [W-1:0] p, input string tag);
        item_t it;
        @(negedge clk);
        rst = r; mode = m; ser_in_up = su; ser_in_down = sd; par_in = p;
        if (r)             model = '0;
        else if (m == 2'b01) model = {sd, model[W-1:1]};
        else if (m == 2'b10) model = {model[W-2:0], su};
        else if (m == 2'b11) model = p;
        it.exp = model;
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: samples 2 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                n_checks++;
                if (q !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s q: actual %b expected %b", it.tag, q, it.exp);
                end
                n_checks++;
                if (ser_out_up !== it.exp[W-1] || ser_out_down !== it.exp[0]) begin
                    n_fail++;
                    $display("FAIL R6 (%s) serial outs up/down: actual %b%b expected %b%b",
                             it.tag, ser_out_up, ser_out_down, it.exp[W-1], it.exp[0]);
                end
            end
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; mode = 2'b00; ser_in_up = 1'b0; ser_in_down = 1'b0; par_in = '0;
        model = '0;
        // R5: reset wins over a load of all ones
        drive(1'b1, 2'b11, 1'b1, 1'b1, '1, "R5 reset over load");
        drive(1'b1, 2'b10, 1'b1, 1'b1, '1, "R5 reset over shift");
        // R4: parallel load
        drive(1'b0, 2'b11, 1'b0, 1'b0, 4'b1010, "R4 load");
        // R1: keep with noisy inputs
        drive(1'b0, 2'b00, 1'b1, 1'b1, 4'b0101, "R1 keep");
        drive(1'b0, 2'b00, 1'b0, 1'b1, 4'b1111, "R1 keep");
        // R2: down shifts with ones and zeros entering at the top
        drive(1'b0, 2'b01, 1'b0, 1'b1, '0, "R2 down fill1");
        drive(1'b0, 2'b01, 1'b1, 1'b0, '0, "R2 down fill0");
        drive(1'b0, 2'b01, 1'b0, 1'b1, '0, "R2 down fill1");
        // R3: up shifts with ones and zeros entering at bit 0
        drive(1'b0, 2'b10, 1'b1, 1'b0, '0, "R3 up fill1");
        drive(1'b0, 2'b10, 1'b0, 1'b1, '0, "R3 up fill0");
        drive(1'b0, 2'b10, 1'b1, 1'b0, '0, "R3 up fill1");
        // R7: flush upward with zero fill
        drive(1'b0, 2'b11, 1'b0, 1'b0, 4'b1111, "R4 load ones");
        for (int i = 0; i < W; i++)
            drive(1'b0, 2'b10, 1'b0, 1'b1, '0, "R7 up flush");
        // R7: flush downward with zero fill
        drive(1'b0, 2'b11, 1'b0, 1'b0, 4'b1001, "R4 load");
        for (int i = 0; i < W; i++)
            drive(1'b0, 2'b01, 1'b1, 1'b0, '0, "R7 down flush");
        // R5: reset in the middle of an upward run
        drive(1'b0, 2'b11, 1'b0, 1'b0, 4'b0110, "R4 load");
        drive(1'b0, 2'b10, 1'b1, 1'b0, '0, "R3 up");
        drive(1'b1, 2'b10, 1'b1, 1'b0, '0, "R5 reset mid-run");
        drive(1'b0, 2'b10, 1'b1, 1'b0, '0, "R3 up after reset");
        // R8: random sequence against the model
        for (int i = 0; i < 400; i++) begin
            logic r;
            r = ($urandom_range(0, 31) == 0);
            drive(r, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 1)), W'($urandom), "R8 random");
        end
        drive(1'b0, 2'b00, 1'b0, 1'b0, '0, "R1 final keep");
        while (sb.size() > 0) @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule